// File: doc/BRIEF.md
# Address Translation Lookaside with Transparent Windows

This block maps a 32-bit logical address to a physical address for a single access stream. Two programmable transparent windows are checked first. A window selects a region by the top eight address bits under a per-bit ignore mask, and passes the address through unchanged. When no window claims the access, the block searches a small fully associative store of recent 4 KB page mappings. A hit returns the physical address, a protection verdict and the page's write-policy bit in the same cycle as the request.

When neither a window nor a stored page claims an access, the block records the missing page number and raises a miss request. The request is held until an external table walker answers on the fill port. The answer is written into the store in round-robin order. A flush input and a root-pointer write strobe each empty the whole store in one cycle. This keeps the mappings of one process out of reach of the next. The table walk itself, the memory cache and the bus are outside this block.

Top module: `addr_xlat_unit`

## Requirements
- R1: After reset no page entry is valid, `missValid` is low and the replacement pointer is at entry 0, so the first lookup of any non-window address misses.
- R2: A window matches when it is enabled, `reqAddr[31:24]` equals its base in every bit where its mask bit is 0, and its mode field permits the access privilege. On a match `respHit` and `respTransparent` are high in the same cycle, `respPhys` equals `reqAddr`, `respCopyback` is low and no miss is raised.
- R3: A matching window takes priority over the page store. When both windows match, window 0 supplies the protection verdict.
- R4: In the mode field, bit 0 permits user accesses and bit 1 permits supervisor accesses. An access that its mode does not permit does not match the window. A write that matches a window whose write-protect bit is set gives `respFault` high.
- R5: A page hit gives `respHit` high in the request cycle, with `respPhys = {frame, reqAddr[11:0]}` and `respCopyback` equal to the stored write-policy bit (1 = copyback, 0 = writethrough).
- R6: A write that hits a page stored with its read-only bit set gives `respFault` high. Reads of that page do not fault.
- R7: A user-mode access (`reqSuper` = 0) that hits a page stored with its supervisor-only bit set gives `respFault` high. Supervisor accesses to that page do not fault.
- R8: A valid request that no window or page claims sets `missValid` on the next clock edge, with `missPage = reqAddr[31:12]`. Both stay unchanged, whatever later requests arrive, until a clock edge with `fillValid` high. After that edge `missValid` is low. No new miss is taken at the edge where a fill is accepted.
- R9: Each accepted fill writes the pending page number with `fillFrame` and its three attribute bits into the entry at the replacement pointer, then advances the pointer by one, wrapping after the last entry. The oldest mapping is thus evicted first. A fill while no miss is pending is ignored.
- R10: A clock edge with `flush` high invalidates every page entry. If a fill arrives at that same edge, it is dropped but still ends the pending miss.
- R11: A clock edge with `rootWrite` high invalidates every page entry in the same way as `flush`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request this cycle |
| reqAddr | input | 32 | Logical address |
| reqWrite | input | 1 | 1 = write access |
| reqSuper | input | 1 | 1 = supervisor privilege, 0 = user |
| win0Base | input | 8 | Window 0 base for address bits 31:24 |
| win0Mask | input | 8 | Window 0 ignore mask (1 = bit not compared) |
| win0Enable | input | 1 | Window 0 enable |
| win0WriteProt | input | 1 | Window 0 write protect |
| win0Mode | input | 2 | Window 0 privilege permit (bit0 user, bit1 supervisor) |
| win1Base | input | 8 | Window 1 base |
| win1Mask | input | 8 | Window 1 ignore mask |
| win1Enable | input | 1 | Window 1 enable |
| win1WriteProt | input | 1 | Window 1 write protect |
| win1Mode | input | 2 | Window 1 privilege permit |
| rootWrite | input | 1 | New root pointer written; invalidates all pages |
| flush | input | 1 | Invalidate all pages |
| fillValid | input | 1 | Walker answer for the pending miss |
| fillFrame | input | 20 | Physical frame number |
| fillReadOnly | input | 1 | Page is read-only |
| fillSuperOnly | input | 1 | Page is supervisor-only |
| fillCopyback | input | 1 | Page write policy (1 copyback) |
| respHit | output | 1 | Request claimed by a window or a page |
| respTransparent | output | 1 | Request claimed by a window |
| respPhys | output | 32 | Physical address (valid with respHit) |
| respFault | output | 1 | Protection fault on this access |
| respCopyback | output | 1 | Write policy of the hit page |
| missValid | output | 1 | Miss request pending |
| missPage | output | 20 | Page number of the pending miss |

## Verification
The bench builds the block with four page entries instead of sixteen. A handful of fills then wraps the replacement pointer, and the randomly chosen page pool regularly exceeds the store, so evictions of the oldest mapping, refills and duplicate-free reuse all occur within a few thousand cycles. The window configuration is rewritten during the run to reach overlapping windows, disabled windows and privilege-filtered windows. Flush, root-pointer writes and fills meet at the same edge in directed cases.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
  localparam int WIN_BITS = 8;

  typedef struct packed {
    logic [WIN_BITS-1:0] base;
    logic [WIN_BITS-1:0] mask;
    logic                en;
    logic                wp;
    logic [1:0]          mode;
  } winCfg_t;

  typedef struct packed {
    logic capture;
    logic install;
    logic clearAll;
  } xlatStrobe_t;
endpackage

// File: rtl/addr_xlat_ctrl.sv
module addr_xlat_ctrl
  import addr_xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupMiss,
  input  logic             fillValid,
  input  logic             flush,
  input  logic             rootWrite,
  output xlatStrobe_t      strobe,
  output logic [IDX_W-1:0] slot,
  output logic             missValid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptrQ;
  logic             pendQ;

  always_comb begin
    strobe.clearAll = flush | rootWrite;
    strobe.capture  = !pendQ && lookupMiss;
    strobe.install  = pendQ && fillValid && !strobe.clearAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      ptrQ  <= '0;
    end else begin
      if (pendQ && fillValid)
        pendQ <= 1'b0;
      else if (strobe.capture)
        pendQ <= 1'b1;
      if (strobe.install)
        ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
    end
  end

  assign slot      = ptrQ;
  assign missValid = pendQ;
endmodule

// File: rtl/addr_xlat_dp.sv
module addr_xlat_dp
  import addr_xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic               reqSuper,
  input  winCfg_t [1:0]      winCfg,
  input  xlatStrobe_t        strobe,
  input  logic [IDX_W-1:0]   slot,
  input  logic [VPN_W-1:0]   fillFrame,
  input  logic               fillReadOnly,
  input  logic               fillSuperOnly,
  input  logic               fillCopyback,
  output logic               respHit,
  output logic               respTransparent,
  output logic [ADDR_W-1:0]  respPhys,
  output logic               respFault,
  output logic               respCopyback,
  output logic               lookupMiss,
  output logic [VPN_W-1:0]   missPage,
  output logic [ENTRIES-1:0] validVec
);
  localparam int WIN_LO = ADDR_W - WIN_BITS;

  logic [1:0]         winHit;
  logic               ttHit;
  logic               winWp;
  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   tagQ   [ENTRIES];
  logic [VPN_W-1:0]   frameQ [ENTRIES];
  logic [ENTRIES-1:0] roQ, soQ, cbQ;
  logic [ENTRIES-1:0] entHit;
  logic               pageHit;
  logic [VPN_W-1:0]   selFrame;
  logic               selRo, selSo, selCb;
  logic [VPN_W-1:0]   missPageQ;
  logic [VPN_W-1:0]   reqPage;

  assign reqPage = reqAddr[ADDR_W-1:PAGE_BITS];

  for (genvar w = 0; w < 2; w++) begin : gWin
    logic modeOk;
    assign modeOk    = reqSuper ? winCfg[w].mode[1] : winCfg[w].mode[0];
    assign winHit[w] = winCfg[w].en && modeOk &&
      (((reqAddr[ADDR_W-1:WIN_LO] ^ winCfg[w].base) & ~winCfg[w].mask) == '0);
  end

  assign ttHit = |winHit;
  assign winWp = winHit[0] ? winCfg[0].wp : winCfg[1].wp;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
    assign entHit[e] = validQ[e] && (tagQ[e] == reqPage);
  end

  always_comb begin
    pageHit  = 1'b0;
    selFrame = '0;
    selRo    = 1'b0;
    selSo    = 1'b0;
    selCb    = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (entHit[e]) begin
        pageHit  = 1'b1;
        selFrame = frameQ[e];
        selRo    = roQ[e];
        selSo    = soQ[e];
        selCb    = cbQ[e];
      end
    end
  end

  always_comb begin
    respTransparent = reqValid && ttHit;
    respHit         = reqValid && (ttHit || pageHit);
    lookupMiss      = reqValid && !ttHit && !pageHit;
    respPhys        = ttHit ? reqAddr : {selFrame, reqAddr[PAGE_BITS-1:0]};
    respCopyback    = reqValid && !ttHit && pageHit && selCb;
    if (ttHit)
      respFault = reqValid && reqWrite && winWp;
    else
      respFault = reqValid && pageHit &&
                  ((reqWrite && selRo) || (!reqSuper && selSo));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      validQ <= '0;
    else if (strobe.clearAll)
      validQ <= '0;
    else if (strobe.install)
      validQ[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.capture)
      missPageQ <= reqPage;
    if (strobe.install) begin
      tagQ[slot]   <= missPageQ;
      frameQ[slot] <= fillFrame;
      roQ[slot]    <= fillReadOnly;
      soQ[slot]    <= fillSuperOnly;
      cbQ[slot]    <= fillCopyback;
    end
  end

  assign missPage = missPageQ;
  assign validVec = validQ;
endmodule

// File: rtl/addr_xlat_unit.sv
module addr_xlat_unit
  import addr_xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W = ADDR_W - PAGE_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqSuper,
  input  logic [WIN_BITS-1:0] win0Base,
  input  logic [WIN_BITS-1:0] win0Mask,
  input  logic                win0Enable,
  input  logic                win0WriteProt,
  input  logic [1:0]          win0Mode,
  input  logic [WIN_BITS-1:0] win1Base,
  input  logic [WIN_BITS-1:0] win1Mask,
  input  logic                win1Enable,
  input  logic                win1WriteProt,
  input  logic [1:0]          win1Mode,
  input  logic                rootWrite,
  input  logic                flush,
  input  logic                fillValid,
  input  logic [VPN_W-1:0]    fillFrame,
  input  logic                fillReadOnly,
  input  logic                fillSuperOnly,
  input  logic                fillCopyback,
  output logic                respHit,
  output logic                respTransparent,
  output logic [ADDR_W-1:0]   respPhys,
  output logic                respFault,
  output logic                respCopyback,
  output logic                missValid,
  output logic [VPN_W-1:0]    missPage
);
  winCfg_t [1:0]      winCfg;
  xlatStrobe_t        strobe;
  logic [IDX_W-1:0]   slot;
  logic               lookupMiss;
  logic [ENTRIES-1:0] validVec;

  assign winCfg[0] = '{base: win0Base, mask: win0Mask, en: win0Enable,
                       wp: win0WriteProt, mode: win0Mode};
  assign winCfg[1] = '{base: win1Base, mask: win1Mask, en: win1Enable,
                       wp: win1WriteProt, mode: win1Mode};

  addr_xlat_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .lookupMiss(lookupMiss), .fillValid(fillValid),
    .flush(flush), .rootWrite(rootWrite), .strobe(strobe), .slot(slot),
    .missValid(missValid)
  );

  addr_xlat_dp #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .winCfg(winCfg),
    .strobe(strobe), .slot(slot), .fillFrame(fillFrame),
    .fillReadOnly(fillReadOnly), .fillSuperOnly(fillSuperOnly),
    .fillCopyback(fillCopyback), .respHit(respHit),
    .respTransparent(respTransparent), .respPhys(respPhys),
    .respFault(respFault), .respCopyback(respCopyback),
    .lookupMiss(lookupMiss), .missPage(missPage), .validVec(validVec)
  );
endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int VPN_W = ADDR_W - PAGE_BITS
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               flush,
  input logic               rootWrite,
  input logic               fillValid,
  input logic               respHit,
  input logic               respTransparent,
  input logic [ADDR_W-1:0]  respPhys,
  input logic               respFault,
  input logic               respCopyback,
  input logic               missValid,
  input logic [VPN_W-1:0]   missPage,
  input logic [ENTRIES-1:0] validVec
);
  assert_window_identity_R2: assert property (@(posedge clk) disable iff (!rstN)
    respTransparent |-> (respHit && respPhys == reqAddr && !respCopyback));

  assert_window_no_miss_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respTransparent && !missValid) |=> !missValid);

  assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respHit);

  assert_hit_no_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && respHit && !missValid) |=> !missValid);

  assert_miss_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !fillValid) |=> (missValid && $stable(missPage)));

  assert_miss_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && fillValid) |=> !missValid);

  assert_miss_raised_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!missValid && reqValid && !respHit) |=> (missValid && missPage == $past(reqAddr[ADDR_W-1:PAGE_BITS])));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));

  assert_root_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    rootWrite |=> (validVec == '0));

  assert_one_install_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !rootWrite) |=> ($countones(validVec) <= $countones($past(validVec)) + 1));
endmodule

bind addr_xlat_unit addr_xlat_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .flush(flush), .rootWrite(rootWrite), .fillValid(fillValid),
  .respHit(respHit), .respTransparent(respTransparent), .respPhys(respPhys),
  .respFault(respFault), .respCopyback(respCopyback), .missValid(missValid),
  .missPage(missPage), .validVec(validVec)
);

// File: tb/addr_xlat_unit_tb_top.sv
module addr_xlat_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENT        = 4;
  localparam int RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSuper = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  wBase [2];
  logic [7:0]  wMask [2];
  logic        wEn [2];
  logic        wWp [2];
  logic [1:0]  wMode [2];
  logic        rootWrite = 1'b0, flush = 1'b0, fillValid = 1'b0;
  logic [19:0] fillFrame = '0;
  logic        fillReadOnly = 1'b0, fillSuperOnly = 1'b0, fillCopyback = 1'b0;
  logic        respHit, respTransparent, respFault, respCopyback, missValid;
  logic [31:0] respPhys;
  logic [19:0] missPage;

  int checks = 0;
  int errors = 0;

  bit        mValid [ENT];
  bit [19:0] mTag   [ENT];
  bit [19:0] mFrame [ENT];
  bit        mRo [ENT], mSo [ENT], mCb [ENT];
  int        mPtr = 0;
  bit        mMissV = 0;
  bit [19:0] mMissP = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlat_unit #(.ENTRIES(ENT)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper),
    .win0Base(wBase[0]), .win0Mask(wMask[0]), .win0Enable(wEn[0]),
    .win0WriteProt(wWp[0]), .win0Mode(wMode[0]),
    .win1Base(wBase[1]), .win1Mask(wMask[1]), .win1Enable(wEn[1]),
    .win1WriteProt(wWp[1]), .win1Mode(wMode[1]),
    .rootWrite(rootWrite), .flush(flush), .fillValid(fillValid),
    .fillFrame(fillFrame), .fillReadOnly(fillReadOnly),
    .fillSuperOnly(fillSuperOnly), .fillCopyback(fillCopyback),
    .respHit(respHit), .respTransparent(respTransparent), .respPhys(respPhys),
    .respFault(respFault), .respCopyback(respCopyback),
    .missValid(missValid), .missPage(missPage)
  );

  function automatic bit winMatch(int w);
    bit permit = reqSuper ? wMode[w][1] : wMode[w][0];
    return wEn[w] && permit && (((reqAddr[31:24] ^ wBase[w]) & ~wMask[w]) == 8'h00);
  endfunction

  function automatic int pageIndex();
    for (int e = 0; e < ENT; e++)
      if (mValid[e] && mTag[e] == reqAddr[31:12]) return e;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the model, then advance one clock and update the model
  task automatic cycle(string tag);
    bit t0, t1, eTt, ePage, eHit, eFault, eCb, clr;
    int pi;
    logic [31:0] ePhys;
    #1;
    t0 = winMatch(0);
    t1 = winMatch(1);
    eTt = reqValid && (t0 || t1);
    pi = pageIndex();
    ePage = reqValid && !eTt && (pi >= 0);
    eHit = eTt || ePage;
    ePhys = eTt ? reqAddr : (ePage ? {mFrame[pi], reqAddr[11:0]} : 32'h0);
    if (eTt) eFault = reqWrite && (t0 ? wWp[0] : wWp[1]);
    else eFault = ePage && ((reqWrite && mRo[pi]) || (!reqSuper && mSo[pi]));
    eCb = ePage && mCb[pi];
    check(tag, "hit", {31'b0, respHit}, {31'b0, eHit});
    check(tag, "transparent", {31'b0, respTransparent}, {31'b0, eTt});
    check(tag, "fault", {31'b0, respFault}, {31'b0, eFault});
    check(tag, "copyback", {31'b0, respCopyback}, {31'b0, eCb});
    if (eHit) check(tag, "phys", respPhys, ePhys);
    check(tag, "missValid", {31'b0, missValid}, {31'b0, mMissV});
    if (mMissV) check(tag, "missPage", {12'b0, missPage}, {12'b0, mMissP});
    @(posedge clk);
    clr = flush || rootWrite;
    if (mMissV && fillValid) begin
      if (!clr) begin
        mValid[mPtr] = 1; mTag[mPtr] = mMissP; mFrame[mPtr] = fillFrame;
        mRo[mPtr] = fillReadOnly; mSo[mPtr] = fillSuperOnly; mCb[mPtr] = fillCopyback;
        mPtr = (mPtr + 1) % ENT;
      end
      mMissV = 0;
    end else if (!mMissV && reqValid && !eHit) begin
      mMissV = 1;
      mMissP = reqAddr[31:12];
    end
    if (clr) for (int e = 0; e < ENT; e++) mValid[e] = 0;
    @(negedge clk);
  endtask

  task automatic req(logic [31:0] a, bit wr, bit sup);
    reqValid = 1; reqAddr = a; reqWrite = wr; reqSuper = sup;
  endtask

  task automatic missAndFill(string tag, logic [31:0] a, logic [19:0] fr, bit ro, bit so, bit cb);
    req(a, 0, 1);
    cycle(tag);
    reqValid = 0;
    fillValid = 1; fillFrame = fr; fillReadOnly = ro; fillSuperOnly = so; fillCopyback = cb;
    cycle(tag);
    fillValid = 0;
  endtask

  task automatic setWin(int w, logic [7:0] b, logic [7:0] m, bit en, bit wp, logic [1:0] md);
    wBase[w] = b; wMask[w] = m; wEn[w] = en; wWp[w] = wp; wMode[w] = md;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    setWin(0, 8'h40, 8'h0F, 1, 0, 2'b11);
    setWin(1, 8'h80, 8'h7F, 1, 1, 2'b01);
    for (int e = 0; e < ENT; e++) mValid[e] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state, first lookup misses
    check("R1", "missValid at reset", {31'b0, missValid}, 32'h0);
    req(32'h0001_2345, 0, 1);
    cycle("R1");
    // R8: miss held while another missing request arrives
    req(32'h0005_5000, 1, 0);
    cycle("R8");
    cycle("R8");
    reqValid = 0;
    fillValid = 1; fillFrame = 20'hABCDE; fillReadOnly = 0; fillSuperOnly = 0; fillCopyback = 1;
    cycle("R8");
    fillValid = 0;
    // R5: page hit with frame substitution and write policy
    req(32'h0001_2FFF, 1, 0);
    cycle("R5");
    // R9: fill while nothing pending is ignored
    reqValid = 0; fillValid = 1; fillFrame = 20'h11111;
    cycle("R9");
    fillValid = 0;
    // R2: identity window, no miss afterward
    req(32'h4A00_1234, 1, 0);
    cycle("R2");
    cycle("R2");
    // R4: window 1 permits only user; supervisor access to it goes to pages
    missAndFill("R4", 32'h9000_0000, 20'h0BEEF, 1, 1, 0);
    req(32'h9000_0010, 1, 1);
    cycle("R6");                       // R6: write to read-only page faults
    req(32'h9000_0010, 0, 1);
    cycle("R6");                       // read of read-only page is fine
    req(32'h9000_0010, 0, 0);
    cycle("R4");                       // user read goes through window 1
    req(32'h9000_0010, 1, 0);
    cycle("R4");                       // user write hits write-protected window
    // R7: supervisor-only page
    missAndFill("R7", 32'h0002_0000, 20'h22222, 0, 1, 0);
    req(32'h0002_0ABC, 0, 0);
    cycle("R7");
    req(32'h0002_0ABC, 0, 1);
    cycle("R7");
    // R3: overlapping windows, window 0 wins
    setWin(1, 8'h40, 8'h00, 1, 1, 2'b11);
    req(32'h4000_0000, 1, 1);
    cycle("R3");
    setWin(0, 8'h40, 8'h0F, 0, 0, 2'b11);
    cycle("R3");
    setWin(0, 8'h00, 8'hFF, 1, 0, 2'b11);  // window over everything beats pages
    req(32'h0001_2000, 0, 1);
    cycle("R3");
    setWin(0, 8'h40, 8'h0F, 1, 0, 2'b11);
    setWin(1, 8'h80, 8'h7F, 1, 1, 2'b01);
    // R10: flush empties the store
    reqValid = 0; flush = 1;
    cycle("R10");
    flush = 0;
    req(32'h0001_2000, 0, 1);
    cycle("R10");
    // R10: flush at the fill edge drops the fill but ends the miss
    reqValid = 0; fillValid = 1; flush = 1; fillFrame = 20'h33333;
    cycle("R10");
    fillValid = 0; flush = 0;
    req(32'h0001_2000, 0, 1);
    cycle("R10");
    reqValid = 0; fillValid = 1; fillFrame = 20'h44444;
    cycle("R10");
    fillValid = 0;
    // R9: five fills into four entries evict the oldest
    for (int p = 0; p < 5; p++)
      missAndFill("R9", {12'h003, p[3:0], 16'h0000}, 20'h50000 + p, 0, 0, p[0]);
    for (int p = 0; p < 5; p++) begin
      req({12'h003, p[3:0], 16'h0123}, 0, 1);
      cycle("R9");
    end
    // R11: root pointer write empties the store
    reqValid = 0; rootWrite = 1;
    cycle("R11");
    rootWrite = 0;
    req(32'h0034_0000, 0, 1);
    cycle("R11");

    // random mix over a small page pool
    for (int i = 0; i < RAND_STEPS; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 6) reqAddr = {12'h001, 4'($urandom_range(0, 6)), 4'h0, 12'($urandom)};
      else if (sel < 8) reqAddr = {8'h40 + 8'($urandom_range(0, 31)), 24'($urandom)};
      else reqAddr = {8'h90, 4'h0, 4'($urandom_range(0, 2)), 16'($urandom)};
      reqValid = ($urandom_range(0, 3) != 0);
      reqWrite = $urandom_range(0, 1);
      reqSuper = $urandom_range(0, 1);
      fillValid = mMissV && ($urandom_range(0, 2) == 0);
      fillFrame = 20'($urandom);
      fillReadOnly = $urandom_range(0, 1);
      fillSuperOnly = ($urandom_range(0, 3) == 0);
      fillCopyback = $urandom_range(0, 1);
      flush = ($urandom_range(0, 49) == 0);
      rootWrite = ($urandom_range(0, 59) == 0);
      cycle("R5 R6 R7 R8 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule